// File: doc/BRIEF.md
# Receive Bit-Timing Recovery Loop

This block rebuilds a receive bit clock from a serial data stream that has already been demodulated to logic levels. It is a counter-based digital phase-locked loop. A phase counter splits each bit period into sixteen steps, one per clock. Every data transition is compared against the counter. The counter is then pulled toward the transition by a small or a large amount. The size of the pull depends on how far off the transition was, on a fast-correction enable and on a lock-speed select.

The block clocks at sixteen times the bit rate, for example 19.2 kHz sample ticks for 1200 bit/s or 38.4 kHz for 2400 bit/s. Its outputs are:
- a recovered bit clock;
- a retimed data bit that is stable across the falling edge of that clock, so downstream logic samples it there;
- a lock flag.

Top module: `rx_bit_timing_dpll`

## Requirements
- R1: While `rst_n` is low at a clock edge, the phase count is cleared and `rx_bit_clk`, `rx_bit_out` and `phase_locked` are 0.
- R2: The input passes two synchronizer flops before edge detection. A transition seen at phase count c has an error of c for c below 8 and c-16 from 8 upward, and the correction lands on the third clock edge after the input changed. With `fast_corr_en`=1, `lock_mode_sel`=1 and an error magnitude above 1, the whole error is removed, so the count reads 1 after that edge.
- R3: With `fast_corr_en`=1, `lock_mode_sel`=0 and an error magnitude above 1, the count is moved by 2 toward the nominal position.
- R4: An error magnitude of 1 moves the count by one step toward zero, and an error of 0 moves it not at all, whatever the mode inputs.
- R5: With `fast_corr_en`=0, every nonzero error moves the count by exactly one step toward zero.
- R6: With `lock_mode_sel`=1 and one transition per bit, `phase_locked` is high within 18 bit periods of the first transition, for any starting phase and either `fast_corr_en` value.
- R7: With `lock_mode_sel`=0 and one transition per bit, `phase_locked` is high within 50 bit periods, for any starting phase and either `fast_corr_en` value.
- R8: `phase_locked` rises after 8 consecutive transitions with an error magnitude of at most 1. It falls after 4 consecutive transitions with a larger error. No other event changes it.
- R9: `rx_bit_out` changes only on the clock where `rx_bit_clk` rises, when it takes the synchronized input as the count enters 8. At each falling edge of `rx_bit_clk` in lock it holds the bit that preceded the one now on the input.
- R10: With no transitions the count advances by one per clock. `rx_bit_clk` is high for counts 8 to 15, giving a 16-clock period with equal high and low halves and a first rise 8 clocks after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, sixteen per bit |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_data_in | input | 1 | Demodulated serial data, asynchronous |
| fast_corr_en | input | 1 | 1 allows the large correction step |
| lock_mode_sel | input | 1 | 1 selects full-error correction (18-bit lock), 0 the limited step (50-bit lock) |
| rx_bit_out | output | 1 | Retimed data bit |
| rx_bit_clk | output | 1 | Recovered bit clock; its falling edge marks valid data |
| phase_locked | output | 1 | Loop lock indicator |

## Verification
An input change needs three clock edges before the correction reaches the phase count: two synchronizer stages and the counter itself. The next rise of `rx_bit_clk` therefore comes 3 + ((8 - v) mod 16) edges after the input change, where v is the corrected count. The bench predicts v from the phase offset it applied and counts edges from its own drive point to the observed rise.

The lock flag moves one edge after the detection cycle, so it is read eight clocks after each transition, before the next one. Retimed data is compared only at the falling edges of `rx_bit_clk`, against the bench's own record of the previous bit. All inputs change and all outputs are read on the falling clock edge.

// File: rtl/bcr_pkg.sv
// Shared types for the bit-timing recovery loop.
// Assumes: one report per detected transition, valid for one clock.
package bcr_pkg;

    // Kind of phase correction chosen for a transition
    typedef enum logic [1:0] {
        CORR_NONE = 2'd0,
        CORR_SLOW = 2'd1,
        CORR_FAST = 2'd2
    } corr_kind_e;

    // Per-clock report handed to the lock monitor
    typedef struct packed {
        logic seen;   // a transition was detected this clock
        logic near;   // its phase error magnitude was at most one step
    } edge_rpt_t;

endpackage

// File: rtl/bcr_rx_sync.sv
// Brings the asynchronous data input into the clock domain and flags
// transitions of the synchronized value.
// Assumes: STAGES >= 2; the flag is valid for the single clock after
// the synchronized value changes.
module bcr_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout,
    output logic edge_seen
);

    logic [STAGES:0] pipe_q;

    // Shift the input through the synchronizer plus one history flop
    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= {pipe_q[STAGES-1:0], din};
    end

    assign dout      = pipe_q[STAGES-1];
    assign edge_seen = pipe_q[STAGES] ^ pipe_q[STAGES-1];

endmodule

// File: rtl/bcr_phase_corrector.sv
// Turns the phase count at a transition into a signed error and works
// out the corrected count for the next clock.
// Assumes: the nominal transition position is count 0, and a correction
// replaces the normal +1 advance on that clock.
module bcr_phase_corrector
    import bcr_pkg::*;
#(
    parameter int PHASE_W  = 4,
    parameter int M0_LIMIT = 2
) (
    input  logic [PHASE_W-1:0] phase,
    input  logic               fast_en,
    input  logic               lock_sel,
    output logic [PHASE_W-1:0] phase_fix,
    output logic               near
);

    localparam int STEPS = 1 << PHASE_W;
    localparam int HALF  = STEPS / 2;
    localparam logic [PHASE_W:0]        SPAN = (PHASE_W+1)'(STEPS);
    localparam logic signed [PHASE_W:0] LIM  = (PHASE_W+1)'(M0_LIMIT);
    localparam logic signed [PHASE_W:0] POS1 = (PHASE_W+1)'(1);
    localparam logic signed [PHASE_W:0] NEG1 = -POS1;

    logic signed [PHASE_W:0] err;
    logic signed [PHASE_W:0] step;
    logic        [PHASE_W:0] mag;
    corr_kind_e              kind;

    // Signed error: upper half of the bit counts as a late local clock
    always_comb begin
        if (int'(phase) < HALF) err = $signed({1'b0, phase});
        else                    err = $signed({1'b0, phase} - SPAN);
        mag  = err[PHASE_W] ? $unsigned(-err) : $unsigned(err);
        near = (mag <= (PHASE_W+1)'(1));
    end

    // Choose the correction kind from error size and mode inputs
    always_comb begin
        if (err == '0)               kind = CORR_NONE;
        else if (!fast_en || near)   kind = CORR_SLOW;
        else                         kind = CORR_FAST;
    end

    // Size the step for the chosen kind
    always_comb begin
        case (kind)
            CORR_SLOW: step = err[PHASE_W] ? NEG1 : POS1;
            CORR_FAST: begin
                if (lock_sel)         step = err;
                else if (err > LIM)   step = LIM;
                else if (err < -LIM)  step = -LIM;
                else                  step = err;
            end
            default:   step = '0;
        endcase
        phase_fix = PHASE_W'({1'b0, phase} + $unsigned(POS1) - $unsigned(step));
    end

endmodule

// File: rtl/bcr_lock_mon.sv
// Tracks runs of small and large phase errors and holds the lock flag.
// Assumes: at most one report per clock; reports without a transition
// leave all state unchanged.
module bcr_lock_mon
    import bcr_pkg::*;
#(
    parameter int GOOD_RUN = 8,
    parameter int BAD_RUN  = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  edge_rpt_t rpt,
    output logic      locked
);

    localparam int GW = $clog2(GOOD_RUN + 1);
    localparam int BW = $clog2(BAD_RUN + 1);

    logic [GW-1:0] good_q;
    logic [BW-1:0] bad_q;

    // Count consecutive good or bad transitions and set or clear the flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            good_q <= '0;
            bad_q  <= '0;
            locked <= 1'b0;
        end else if (rpt.seen) begin
            if (rpt.near) begin
                bad_q <= '0;
                if (good_q != GW'(GOOD_RUN)) good_q <= good_q + 1'b1;
                if (good_q == GW'(GOOD_RUN - 1)) locked <= 1'b1;
            end else begin
                good_q <= '0;
                if (bad_q != BW'(BAD_RUN)) bad_q <= bad_q + 1'b1;
                if (bad_q == BW'(BAD_RUN - 1)) locked <= 1'b0;
            end
        end
    end

    AST_LOCK_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(rpt.seen && rpt.near)); // R8
    AST_LOCK_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> $past(rpt.seen && !rpt.near)); // R8
    AST_LOCK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rpt.seen |=> $stable(locked)); // R8

endmodule

// File: rtl/rx_bit_timing_dpll.sv
// Receive bit-timing recovery loop. A phase counter runs through one
// bit period per wrap and is pulled toward each detected data transition.
// The top half of the count drives the recovered clock, and data is
// captured as the count enters the top half.
// Assumes: clk runs at 2**PHASE_W times the bit rate; mode inputs are
// quasi-static.
module rx_bit_timing_dpll
    import bcr_pkg::*;
#(
    parameter int PHASE_W       = 4,
    parameter int SYNC_STAGES   = 2,
    parameter int M0_STEP_LIMIT = 2,
    parameter int LOCK_GOOD_RUN = 8,
    parameter int LOCK_BAD_RUN  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_data_in,
    input  logic fast_corr_en,
    input  logic lock_mode_sel,
    output logic rx_bit_out,
    output logic rx_bit_clk,
    output logic phase_locked
);

    localparam int STEPS = 1 << PHASE_W;
    localparam int MSB   = PHASE_W - 1;

    logic               data_s;
    logic               edge_s;
    logic               near;
    logic [PHASE_W-1:0] phase_q;
    logic [PHASE_W-1:0] phase_d;
    logic [PHASE_W-1:0] phase_fix;
    edge_rpt_t          rpt;

    bcr_rx_sync #(
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .din       (rx_data_in),
        .dout      (data_s),
        .edge_seen (edge_s)
    );

    bcr_phase_corrector #(
        .PHASE_W  (PHASE_W),
        .M0_LIMIT (M0_STEP_LIMIT)
    ) i_corr (
        .phase     (phase_q),
        .fast_en   (fast_corr_en),
        .lock_sel  (lock_mode_sel),
        .phase_fix (phase_fix),
        .near      (near)
    );

    // Report every transition and its error class to the lock monitor
    always_comb begin
        rpt.seen = edge_s;
        rpt.near = near;
    end

    bcr_lock_mon #(
        .GOOD_RUN (LOCK_GOOD_RUN),
        .BAD_RUN  (LOCK_BAD_RUN)
    ) i_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .rpt    (rpt),
        .locked (phase_locked)
    );

    // Next phase: corrected on a transition, otherwise a plain advance
    always_comb begin
        phase_d = edge_s ? phase_fix : PHASE_W'(phase_q + 1'b1);
    end

    // Phase counter register
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_d;
    end

    // Capture the data bit as the phase enters the upper half
    always_ff @(posedge clk) begin
        if (!rst_n)                           rx_bit_out <= 1'b0;
        else if (phase_d[MSB] && !phase_q[MSB]) rx_bit_out <= data_s;
    end

    assign rx_bit_clk = phase_q[MSB];

    AST_FULL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_s && fast_corr_en && lock_mode_sel) |=> (phase_q == PHASE_W'(1))); // R2
    AST_M0_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_s && !lock_mode_sel) |=>
        ((int'(PHASE_W'($past(phase_q) + 1'b1 - phase_q)) <= M0_STEP_LIMIT) ||
         (int'(PHASE_W'($past(phase_q) + 1'b1 - phase_q)) >= STEPS - M0_STEP_LIMIT))); // R3
    AST_SLOW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_s && !fast_corr_en) |=>
        ((int'(PHASE_W'($past(phase_q) + 1'b1 - phase_q)) <= 1) ||
         (int'(PHASE_W'($past(phase_q) + 1'b1 - phase_q)) >= STEPS - 1))); // R5
    AST_FREE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_s |=> (phase_q == PHASE_W'($past(phase_q) + 1'b1))); // R10
    AST_BIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(rx_bit_clk) |-> $stable(rx_bit_out)); // R9

endmodule

// File: tb/test_rx_bit_timing_dpll.sv
module test_rx_bit_timing_dpll;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_in = 1'b0;
    logic fast_en = 1'b0;
    logic sel = 1'b0;
    logic rx_bit, rx_clk, locked;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    rx_bit_timing_dpll i_rx_bit_timing_dpll (
        .clk           (clk),
        .rst_n         (rst_n),
        .rx_data_in    (rx_in),
        .fast_corr_en  (fast_en),
        .lock_mode_sel (sel),
        .rx_bit_out    (rx_bit),
        .rx_bit_clk    (rx_clk),
        .phase_locked  (locked)
    );

    // One vector: mode inputs, phase jump of the shifted transition,
    // edges from that input change to the next rise of the bit clock.
    typedef struct packed {
        logic fast;
        logic msel;
        int   shift;
        int   exp_d;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b1,  4, 10},   // R2 full removal
        '{1'b1, 1'b1, -3, 10},   // R2
        '{1'b1, 1'b1, -6, 10},   // R2
        '{1'b1, 1'b1,  2, 10},   // R2
        '{1'b1, 1'b0,  4,  8},   // R3 limited to 2
        '{1'b1, 1'b0, -6, 14},   // R3
        '{1'b1, 1'b0,  6,  6},   // R3
        '{1'b1, 1'b0, -3, 11},   // R3
        '{1'b1, 1'b1,  1, 10},   // R4 one-step error
        '{1'b1, 1'b1, -1, 10},   // R4
        '{1'b0, 1'b1,  4,  7},   // R5 slow only
        '{1'b0, 1'b0, -6, 15},   // R5
        '{1'b0, 1'b1,  2,  9},   // R5
        '{1'b0, 1'b0,  6,  5}    // R5
    };

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input bit f, input bit s);
        @(negedge clk);
        rst_n = 1'b0; fast_en = f; sel = s; rx_in = 1'b0;
        wait_n(3);
        rst_n = 1'b1;
    endtask

    // Alternating data, one transition per bit; the last bit length is given
    task automatic preamble(input int nbits, input int last_len);
        for (int i = 0; i < nbits; i++) begin
            rx_in = ~rx_in;
            wait_n(i == nbits - 1 ? last_len : 16);
        end
    endtask

    task automatic run_vec(input vec_t v);
        int  d;
        bit  prev;
        string req;
        if (!v.fast)                     req = "R5";
        else if (v.shift >= -1 && v.shift <= 1) req = "R4";
        else if (v.msel)                 req = "R2";
        else                             req = "R3";
        do_reset(v.fast, v.msel);
        wait_n(5);
        preamble(24, 16 + v.shift);
        rx_in = ~rx_in;
        prev = rx_clk;
        d = 0;
        for (int t = 0; t < 24; t++) begin
            @(posedge clk);
            d++;
            @(negedge clk);
            if (!prev && rx_clk) break;
            prev = rx_clk;
        end
        check(d == v.exp_d, req, "edges to clock rise after phase jump", d, v.exp_d);
    endtask

    task automatic lock_run(input int off, input bit f, input bit s);
        int bits = 0;
        bit got = 0;
        int bound = s ? 18 : 50;
        do_reset(f, s);
        wait_n(2 + off);
        for (int b = 0; b < 60 && !got; b++) begin
            rx_in = ~rx_in;
            wait_n(16);
            bits++;
            if (locked) got = 1;
        end
        check(got && bits <= bound, s ? "R6" : "R7", "bit periods to lock", bits, bound);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : main
        int highs, first_rise;
        bit prev_clk;
        bit tx_prev;
        logic [7:0] lf;

        // R1: outputs held low in reset while the input toggles
        rst_n = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            rx_in = ~rx_in;
        end
        @(negedge clk);
        check(rx_clk == 1'b0, "R1", "rx_bit_clk in reset", rx_clk, 0);
        check(rx_bit == 1'b0, "R1", "rx_bit_out in reset", rx_bit, 0);
        check(locked == 1'b0, "R1", "phase_locked in reset", locked, 0);

        // R10: free-running clock shape with a quiet input
        do_reset(1'b1, 1'b1);
        highs = 0; first_rise = -1; prev_clk = 1'b0;
        for (int i = 1; i <= 64; i++) begin
            @(negedge clk);
            if (rx_clk) highs++;
            if (rx_clk && !prev_clk && first_rise < 0) first_rise = i;
            prev_clk = rx_clk;
        end
        check(first_rise == 8, "R10", "first clock rise after reset", first_rise, 8);
        check(highs == 32, "R10", "high cycles in four periods", highs, 32);

        // Vector table: one phase jump per entry
        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R6 and R7: lock time from assorted starting phases
        for (int m = 0; m < 4; m++)
            for (int o = 0; o < 16; o += 3)
                lock_run(o, m[0], m[1]);

        // R8: lock drops after four large errors and returns after eight small
        do_reset(1'b0, 1'b1);
        wait_n(5);
        preamble(24, 24);
        check(locked == 1'b1, "R8", "locked before phase jump", locked, 1);
        for (int i = 1; i <= 15; i++) begin
            rx_in = ~rx_in;
            wait_n(8);
            if (i == 3)  check(locked == 1'b1, "R8", "still locked after 3 large errors", locked, 1);
            if (i == 4)  check(locked == 1'b0, "R8", "unlocked after 4 large errors", locked, 0);
            if (i == 14) check(locked == 1'b0, "R8", "unlocked after 7 small errors", locked, 0);
            if (i == 15) check(locked == 1'b1, "R8", "relocked after 8 small errors", locked, 1);
            wait_n(8);
        end

        // R9: retimed data at falling edges of the recovered clock
        do_reset(1'b1, 1'b1);
        wait_n(5);
        preamble(20, 16);
        lf = 8'hA5;
        prev_clk = rx_clk;
        for (int j = 0; j < 48; j++) begin
            tx_prev = rx_in;
            rx_in = lf[0];
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            for (int t = 0; t < 16; t++) begin
                @(negedge clk);
                if (prev_clk && !rx_clk)
                    check(rx_bit == tx_prev, "R9", "data at clock fall", rx_bit, tx_prev);
                prev_clk = rx_clk;
            end
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule